// File: doc/BRIEF.md
# Clock Reference Trust Monitor

This block watches the health of the timing chain that feeds a packet gateway. It takes two reference-valid indications and a PLL lock indication. From these it picks which reference is active and keeps a three-valued clock condition: locked, holdover or unlocked. It times holdover intervals, counts losses of lock and measures how long each relock takes. It also drives two outputs that telemetry samplers use. A degraded flag marks measurements taken in an untrusted window, and a strict-proof gate allows latency evidence only when the timing chain is stable.

Every reference switch and every change of clock condition produces one event record. Each record carries a running identifier, the timestamp of that clock edge, the new selection and the new condition. Records queue in a small FIFO that the consumer drains with a pop strobe. A sticky overflow bit shows that records were lost. The same records carry reference switches, lock alarms and holdover alarms, so one consumer sees every timing event in the order it happened.

Top module: `ctm_top`

## Requirements
- R1: Reference A is preferred (`sel_ref_b`=0). The block moves to B only at the clock edge where A has been sampled invalid on DEB_CYC consecutive edges and B is valid at that edge. It returns to A at the edge where A has been sampled valid on DEB_CYC consecutive edges. A B-invalid input has no effect while A is selected.
- R2: `clk_state` uses 0=locked, 1=holdover and 2=unlocked, and reset leaves it at 2. From locked, if the PLL lock is held and the active reference is invalid, the state goes to holdover. From holdover, a valid active reference returns the state to locked. From unlocked, lock together with a valid active reference moves the state to locked.
- R3: `hold_time` is cleared when holdover is entered and rises by one on each edge spent in holdover. When it reaches HOLD_LIMIT the state goes to unlocked.
- R4: `unlock_count` rises by exactly one on each edge where the PLL lock is low while the state is locked or holdover. That edge moves the state to unlocked.
- R5: When unlocked is left, `relock_time` is loaded with the number of clock edges at which the state was unlocked. It holds that value until the next relock.
- R6: `degraded` is high when the state is not locked, and also for SETTLE_CYC edges after a reference switch or after entry into locked. `strict_ok` is always its inverse.
- R7: `alarm_code` holds the cause of the last alarm: 1 = active reference lost (entry to holdover), 2 = PLL lock lost, 3 = holdover limit reached. Reset sets it to 0.
- R8: Each edge with a reference switch, a state change or both creates one record. The record holds the identifier (starting at 0 and rising by one per record, including dropped ones), `ts_now` at that edge, a switch flag, a state-change flag, the new selection and the new state.
- R9: Records leave in arrival order. A record that arrives while the FIFO holds FIFO_DEPTH entries and no pop is made is dropped, and this sets `evt_overflow` until reset.
- R10: `evt_valid` is high while the FIFO holds a record, and the head fields are shown on the `evt_*` outputs. `evt_pop` with `evt_valid` high removes the head at the next edge. A pop on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a_ok | input | 1 | Reference A valid |
| ref_b_ok | input | 1 | Reference B valid |
| pll_lock | input | 1 | PLL lock indication |
| ts_now | input | TS_W | Free-running timestamp |
| evt_pop | input | 1 | Remove head event record |
| sel_ref_b | output | 1 | Active reference, 0=A, 1=B |
| clk_state | output | 2 | 0 locked, 1 holdover, 2 unlocked |
| hold_time | output | CNT_W | Edges spent in current/last holdover |
| unlock_count | output | CNT_W | Lock-loss events |
| relock_time | output | CNT_W | Edges spent in last unlocked interval |
| degraded | output | 1 | Untrusted measurement window |
| strict_ok | output | 1 | Strict-proof metrics allowed |
| alarm_code | output | 2 | Last alarm cause |
| evt_valid | output | 1 | Head record present |
| evt_id | output | ID_W | Head record identifier |
| evt_ts | output | TS_W | Head record timestamp |
| evt_is_switch | output | 1 | Head record includes a reference switch |
| evt_is_state | output | 1 | Head record includes a state change |
| evt_ref_b | output | 1 | Selection after the event |
| evt_state | output | 2 | State after the event |
| evt_overflow | output | 1 | Sticky record-drop flag |

## Verification
The bench targets a one- or two-edge glitch on reference A. A design with a debounce error would switch to B and log a switch record; a correct one only passes through holdover. It measures relock time exactly: an off-by-one run counter would report 4 or 6 edges instead of 5. It keeps holdover going up to the limit, where a comparison at the wrong bound leaves the state one edge early or late. It also fills the record queue with the consumer stalled. A FIFO that overwrote entries, dropped the wrong one or cleared the overflow bit would show a wrong identifier sequence or a cleared flag once the queue is drained.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

  typedef enum logic [1:0] {
    CS_LOCKED   = 2'd0,
    CS_HOLDOVER = 2'd1,
    CS_UNLOCKED = 2'd2
  } clk_state_e;

  localparam logic [1:0] AL_NONE         = 2'd0;
  localparam logic [1:0] AL_REF_LOST     = 2'd1;
  localparam logic [1:0] AL_PLL_UNLOCK   = 2'd2;
  localparam logic [1:0] AL_HOLD_EXPIRED = 2'd3;

  // strict evidence is allowed only in a settled locked condition
  function automatic logic trust_gate(input clk_state_e s, input logic settling);
    return (s == CS_LOCKED) && !settling;
  endfunction

endpackage

// File: rtl/ctm_ref_select.sv
module ctm_ref_select #(
  parameter int DEB_CYC = 4,
  localparam int DW = $clog2(DEB_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_a_ok,
  input  logic ref_b_ok,
  output logic sel_b_q,
  output logic sel_b_n,
  output logic switch_evt
);

  logic [DW-1:0] bad_q, good_q, bad_n, good_n;

  function automatic logic [DW-1:0] run_step(input logic [DW-1:0] v);
    return (v == DW'(DEB_CYC)) ? v : v + DW'(1);
  endfunction

  always_comb begin
    bad_n  = ref_a_ok ? '0 : run_step(bad_q);
    good_n = ref_a_ok ? run_step(good_q) : '0;
    switch_evt = (!sel_b_q && (bad_n == DW'(DEB_CYC)) && ref_b_ok) ||
                 ( sel_b_q && (good_n == DW'(DEB_CYC)));
    sel_b_n = switch_evt ? !sel_b_q : sel_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q   <= '0;
      good_q  <= '0;
      sel_b_q <= 1'b0;
    end else begin
      bad_q   <= bad_n;
      good_q  <= good_n;
      sel_b_q <= sel_b_n;
    end
  end

endmodule

// File: rtl/ctm_state_fsm.sv
module ctm_state_fsm
  import ctm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 8,
  parameter int HOLD_LIMIT = 20,
  localparam int SW = $clog2(SETTLE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_lock,
  input  logic             act_ok,
  input  logic             switch_evt,
  output clk_state_e       state_q,
  output clk_state_e       state_n,
  output logic             state_chg,
  output logic [1:0]       alarm_q,
  output logic [CNT_W-1:0] hold_q,
  output logic [CNT_W-1:0] unlock_q,
  output logic [CNT_W-1:0] relock_q,
  output logic             degraded
);

  logic [1:0]       alarm_n;
  logic [CNT_W-1:0] hold_n, run_q, run_n, relock_n;
  logic             unlock_inc;
  logic [SW-1:0]    settle_q, settle_n;
  logic             enter_locked;

  always_comb begin
    state_n    = state_q;
    alarm_n    = alarm_q;
    hold_n     = hold_q;
    run_n      = run_q;
    relock_n   = relock_q;
    unlock_inc = 1'b0;
    unique case (state_q)
      CS_LOCKED: begin
        run_n = '0;
        if (!pll_lock) begin
          state_n    = CS_UNLOCKED;
          alarm_n    = AL_PLL_UNLOCK;
          unlock_inc = 1'b1;
        end else if (!act_ok) begin
          state_n = CS_HOLDOVER;
          alarm_n = AL_REF_LOST;
          hold_n  = '0;
        end
      end
      CS_HOLDOVER: begin
        run_n  = '0;
        hold_n = hold_q + CNT_W'(1);
        if (!pll_lock) begin
          state_n    = CS_UNLOCKED;
          alarm_n    = AL_PLL_UNLOCK;
          unlock_inc = 1'b1;
        end else if (act_ok) begin
          state_n = CS_LOCKED;
        end else if (hold_n == CNT_W'(HOLD_LIMIT)) begin
          state_n = CS_UNLOCKED;
          alarm_n = AL_HOLD_EXPIRED;
        end
      end
      CS_UNLOCKED: begin
        if (pll_lock && act_ok) begin
          state_n  = CS_LOCKED;
          relock_n = run_q + CNT_W'(1);
          run_n    = '0;
        end else begin
          run_n = run_q + CNT_W'(1);
        end
      end
      default: state_n = CS_UNLOCKED;
    endcase
  end

  assign state_chg    = (state_n != state_q);
  assign enter_locked = (state_n == CS_LOCKED) && (state_q != CS_LOCKED);

  always_comb begin
    if (switch_evt || enter_locked) settle_n = SW'(SETTLE_CYC);
    else if (settle_q != '0)        settle_n = settle_q - SW'(1);
    else                            settle_n = settle_q;
  end

  assign degraded = !trust_gate(state_q, settle_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CS_UNLOCKED;
      alarm_q  <= AL_NONE;
      hold_q   <= '0;
      run_q    <= '0;
      relock_q <= '0;
      unlock_q <= '0;
      settle_q <= '0;
    end else begin
      state_q  <= state_n;
      alarm_q  <= alarm_n;
      hold_q   <= hold_n;
      run_q    <= run_n;
      relock_q <= relock_n;
      settle_q <= settle_n;
      if (unlock_inc) unlock_q <= unlock_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ctm_evt_fifo.sv
module ctm_evt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          valid,
  output logic [CW-1:0] count_o,
  output logic          ovf,
  output logic          drop
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          pop_ok, full, acc;

  assign pop_ok  = pop && (cnt_q != '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign acc     = push && (!full || pop_ok);
  assign drop    = push && !acc;
  assign valid   = (cnt_q != '0);
  assign dout    = mem[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (acc) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      if (acc)    wr_q <= wr_q + AW'(1);
      if (pop_ok) rd_q <= rd_q + AW'(1);
      case ({acc, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (drop) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/ctm_top.sv
module ctm_top
  import ctm_pkg::*;
#(
  parameter int TS_W       = 32,
  parameter int ID_W       = 8,
  parameter int CNT_W      = 16,
  parameter int DEB_CYC    = 4,
  parameter int SETTLE_CYC = 8,
  parameter int HOLD_LIMIT = 20,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_a_ok,
  input  logic             ref_b_ok,
  input  logic             pll_lock,
  input  logic [TS_W-1:0]  ts_now,
  input  logic             evt_pop,
  output logic             sel_ref_b,
  output logic [1:0]       clk_state,
  output logic [CNT_W-1:0] hold_time,
  output logic [CNT_W-1:0] unlock_count,
  output logic [CNT_W-1:0] relock_time,
  output logic             degraded,
  output logic             strict_ok,
  output logic [1:0]       alarm_code,
  output logic             evt_valid,
  output logic [ID_W-1:0]  evt_id,
  output logic [TS_W-1:0]  evt_ts,
  output logic             evt_is_switch,
  output logic             evt_is_state,
  output logic             evt_ref_b,
  output logic [1:0]       evt_state,
  output logic             evt_overflow
);

  localparam int REC_W = ID_W + TS_W + 5;
  localparam int FCW   = $clog2(FIFO_DEPTH + 1);

  // named internal events
  logic             sel_b_n, switch_evt, act_ok, state_chg, rec_push, rec_drop;
  clk_state_e       state_q, state_n;
  logic [ID_W-1:0]  id_q;
  logic [REC_W-1:0] rec_in, rec_out;
  logic [FCW-1:0]   fifo_count;

  ctm_ref_select #(.DEB_CYC(DEB_CYC)) u_sel (
    .clk, .rst_n, .ref_a_ok, .ref_b_ok,
    .sel_b_q(sel_ref_b), .sel_b_n, .switch_evt
  );

  assign act_ok = sel_ref_b ? ref_b_ok : ref_a_ok;

  ctm_state_fsm #(
    .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC), .HOLD_LIMIT(HOLD_LIMIT)
  ) u_fsm (
    .clk, .rst_n, .pll_lock, .act_ok, .switch_evt,
    .state_q, .state_n, .state_chg,
    .alarm_q(alarm_code), .hold_q(hold_time), .unlock_q(unlock_count),
    .relock_q(relock_time), .degraded
  );

  assign clk_state = state_q;
  assign strict_ok = !degraded;

  assign rec_push = switch_evt || state_chg;
  assign rec_in   = {id_q, ts_now, switch_evt, state_chg, sel_b_n, state_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        id_q <= '0;
    else if (rec_push) id_q <= id_q + ID_W'(1);
  end

  ctm_evt_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n, .push(rec_push), .din(rec_in), .pop(evt_pop),
    .dout(rec_out), .valid(evt_valid), .count_o(fifo_count),
    .ovf(evt_overflow), .drop(rec_drop)
  );

  assign {evt_id, evt_ts, evt_is_switch, evt_is_state, evt_ref_b, evt_state} = rec_out;

endmodule

// File: rtl/ctm_chk.sv
module ctm_chk #(
  parameter int CNT_W = 16,
  parameter int FCW   = 3,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_a_ok,
  input logic             ref_b_ok,
  input logic             sel_ref_b,
  input logic [1:0]       clk_state,
  input logic             strict_ok,
  input logic             switch_evt,
  input logic [CNT_W-1:0] unlock_count,
  input logic [CNT_W-1:0] hold_time,
  input logic             evt_overflow,
  input logic             rec_push,
  input logic [FCW-1:0]   fifo_count
);

  // R1
  sel_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_ref_b) |-> (!$past(ref_a_ok) && $past(ref_b_ok)));

  // R6
  strict_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strict_ok |-> (clk_state == 2'd0));

  // R6
  switch_degraded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_evt |=> !strict_ok);

  // R4
  unlock_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_count != $past(unlock_count)) |->
      (unlock_count == $past(unlock_count) + CNT_W'(1)));

  // R3
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_state == 2'd1) && ($past(clk_state) != 2'd1)) |-> (hold_time == '0));

  // R8
  state_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_state != $past(clk_state)) |-> $past(rec_push));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overflow |=> evt_overflow);

  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= FCW'(DEPTH));

endmodule

bind ctm_top ctm_chk #(.CNT_W(CNT_W), .FCW(FCW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_a_ok(ref_a_ok), .ref_b_ok(ref_b_ok),
  .sel_ref_b(sel_ref_b), .clk_state(clk_state), .strict_ok(strict_ok),
  .switch_evt(switch_evt), .unlock_count(unlock_count), .hold_time(hold_time),
  .evt_overflow(evt_overflow), .rec_push(rec_push), .fifo_count(fifo_count)
);

// File: tb/sim_ctm_top.sv
module sim_ctm_top;

  localparam int CLK_PERIOD = 10;
  localparam int TS_W = 32, ID_W = 8, CNT_W = 16;
  localparam int DEB = 4, SETTLE = 8, HLIM = 20, DEPTH = 4;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_a_ok = 1'b1, ref_b_ok = 1'b1, pll_lock = 1'b0, evt_pop = 1'b0;
  logic [TS_W-1:0] ts_now = '0;
  logic sel_ref_b, degraded, strict_ok, evt_valid, evt_is_switch, evt_is_state, evt_ref_b, evt_overflow;
  logic [1:0] clk_state, alarm_code, evt_state;
  logic [CNT_W-1:0] hold_time, unlock_count, relock_time;
  logic [ID_W-1:0] evt_id;
  logic [TS_W-1:0] evt_ts;

  int checks = 0, failures = 0, tsv = 0;
  bit pop_en = 1'b1, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctm_top #(.TS_W(TS_W), .ID_W(ID_W), .CNT_W(CNT_W), .DEB_CYC(DEB),
            .SETTLE_CYC(SETTLE), .HOLD_LIMIT(HLIM), .FIFO_DEPTH(DEPTH)) u0 (
    .clk, .rst_n, .ref_a_ok, .ref_b_ok, .pll_lock, .ts_now, .evt_pop,
    .sel_ref_b, .clk_state, .hold_time, .unlock_count, .relock_time,
    .degraded, .strict_ok, .alarm_code, .evt_valid, .evt_id, .evt_ts,
    .evt_is_switch, .evt_is_state, .evt_ref_b, .evt_state, .evt_overflow
  );

  // behavioural reference model
  typedef struct { int id; int ts; bit sw; bit st; int rf; int sv; } rec_t;
  rec_t q[$];
  int m_sel, m_bad, m_good, m_st, m_hold, m_unl, m_rel, m_run, m_settle, m_al, m_id;
  bit m_ovf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_bad = 0; m_good = 0; m_st = 2; m_hold = 0; m_unl = 0;
      m_rel = 0; m_run = 0; m_settle = 0; m_al = 0; m_id = 0; m_ovf = 0;
      q.delete();
    end else begin
      bit act, sw, popd;
      int nst, nsel;
      rec_t r;
      act = m_sel ? ref_b_ok : ref_a_ok;
      m_bad  = ref_a_ok ? 0 : ((m_bad  < DEB) ? m_bad + 1  : DEB);
      m_good = ref_a_ok ? ((m_good < DEB) ? m_good + 1 : DEB) : 0;
      sw = (m_sel == 0 && m_bad == DEB && ref_b_ok) || (m_sel == 1 && m_good == DEB);
      nsel = sw ? 1 - m_sel : m_sel;
      nst = m_st;
      if (m_st == 0) begin
        m_run = 0;
        if (!pll_lock) begin nst = 2; m_unl++; m_al = 2; end
        else if (!act) begin nst = 1; m_al = 1; m_hold = 0; end
      end else if (m_st == 1) begin
        m_run = 0; m_hold++;
        if (!pll_lock) begin nst = 2; m_unl++; m_al = 2; end
        else if (act) nst = 0;
        else if (m_hold == HLIM) begin nst = 2; m_al = 3; end
      end else begin
        if (pll_lock && act) begin nst = 0; m_rel = m_run + 1; m_run = 0; end
        else m_run++;
      end
      if (sw || (nst == 0 && m_st != 0)) m_settle = SETTLE;
      else if (m_settle > 0) m_settle--;
      popd = evt_pop && q.size() > 0;
      if (sw || nst != m_st) begin
        r.id = m_id % 256; r.ts = tsv; r.sw = sw; r.st = (nst != m_st); r.rf = nsel; r.sv = nst;
        m_id++;
        if (q.size() < DEPTH || popd) begin
          if (popd) begin void'(q.pop_front()); popd = 0; end
          q.push_back(r);
        end else m_ovf = 1;
      end
      if (popd) void'(q.pop_front());
      m_sel = nsel; m_st = nst;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit mdeg;
    mdeg = (m_st != 0) || (m_settle != 0);
    chk(sel_ref_b == m_sel, "R1", "sel_ref_b", sel_ref_b, m_sel);
    chk(clk_state == m_st, "R2", "clk_state", clk_state, m_st);
    chk(hold_time == m_hold, "R3", "hold_time", hold_time, m_hold);
    chk(unlock_count == m_unl, "R4", "unlock_count", unlock_count, m_unl);
    chk(relock_time == m_rel, "R5", "relock_time", relock_time, m_rel);
    chk(degraded == mdeg && strict_ok == !mdeg, "R6", "degraded", degraded, mdeg);
    chk(alarm_code == m_al, "R7", "alarm_code", alarm_code, m_al);
    chk(evt_valid == (q.size() > 0), "R10", "evt_valid", evt_valid, q.size() > 0);
    if (q.size() > 0 && evt_valid) begin
      chk(evt_id == q[0].id, "R8", "evt_id", evt_id, q[0].id);
      chk(evt_ts == q[0].ts, "R8", "evt_ts", evt_ts, q[0].ts);
      chk({evt_is_switch, evt_is_state} == {q[0].sw, q[0].st}, "R8", "evt_kind",
          {evt_is_switch, evt_is_state}, {q[0].sw, q[0].st});
      chk(evt_ref_b == q[0].rf && evt_state == q[0].sv, "R8", "evt_ref_state",
          {evt_ref_b, evt_state}, {q[0].rf[0], q[0].sv[1:0]});
    end
    chk(evt_overflow == m_ovf, "R9", "evt_overflow", evt_overflow, m_ovf);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      tsv++;
      ts_now = TS_W'(tsv);
      evt_pop = pop_en && evt_valid;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: unlocked, A selected, untrusted, empty queue
    chk(clk_state == 2'd2, "R2", "reset clk_state", clk_state, 2);
    chk(sel_ref_b == 1'b0, "R1", "reset sel", sel_ref_b, 0);
    chk(degraded && !strict_ok, "R6", "reset degraded", degraded, 1);
    chk(!evt_valid && !evt_overflow && alarm_code == 2'd0, "R9", "reset fifo",
        {evt_valid, evt_overflow}, 0);
    rst_n = 1'b1;
    step(3);
    pll_lock = 1'b1;
    step(2);
    chk(clk_state == 2'd0, "R2", "bring-up locked", clk_state, 0);
    chk(relock_time == 16'd4, "R5", "bring-up relock", relock_time, 4);
    step(10);
    chk(strict_ok == 1'b1, "R6", "settled strict_ok", strict_ok, 1);
    // short glitch on A: holdover only, no switch
    ref_a_ok = 1'b0; step(2); ref_a_ok = 1'b1; step(3);
    chk(sel_ref_b == 1'b0, "R1", "glitch keeps A", sel_ref_b, 0);
    chk(alarm_code == 2'd1, "R7", "ref lost alarm", alarm_code, 1);
    step(10);
    // B loss while A active is ignored
    ref_b_ok = 1'b0; step(3);
    chk(sel_ref_b == 1'b0 && clk_state == 2'd0, "R1", "B loss ignored", {sel_ref_b, clk_state}, 0);
    ref_b_ok = 1'b1; step(2);
    // sustained loss of A: fall back to B, then return
    ref_a_ok = 1'b0; step(6);
    chk(sel_ref_b == 1'b1, "R1", "fallback to B", sel_ref_b, 1);
    ref_a_ok = 1'b1; step(6);
    chk(sel_ref_b == 1'b0, "R1", "return to A", sel_ref_b, 0);
    step(12);
    // loss of lock for five edges
    pll_lock = 1'b0; step(5); pll_lock = 1'b1; step(2);
    chk(unlock_count == 16'd1, "R4", "unlock count", unlock_count, 1);
    chk(relock_time == 16'd5, "R5", "relock edges", relock_time, 5);
    chk(alarm_code == 2'd2, "R7", "unlock alarm", alarm_code, 2);
    step(12);
    // both references gone: holdover runs out
    ref_a_ok = 1'b0; ref_b_ok = 1'b0; step(25);
    chk(clk_state == 2'd2 && hold_time == 16'd20, "R3", "holdover expiry", hold_time, 20);
    chk(alarm_code == 2'd3, "R7", "expiry alarm", alarm_code, 3);
    ref_a_ok = 1'b1; ref_b_ok = 1'b1; step(14);
    // stall the consumer and overflow the queue
    pop_en = 1'b0;
    step(1);
    for (int g = 0; g < 3; g++) begin
      ref_a_ok = 1'b0; step(1); ref_a_ok = 1'b1; step(2);
    end
    chk(evt_overflow == 1'b1, "R9", "overflow sticky", evt_overflow, 1);
    pop_en = 1'b1;
    step(10);
    chk(!evt_valid && evt_overflow, "R10", "drained queue", evt_valid, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule